// File: doc/BRIEF.md
# Packed Binary64 Compare Unit

This block compares up to eight pairs of IEEE-754 binary64 lanes under one shared predicate code and returns the outcome in one of three formats. In the two word-result modes, each active lane yields a 64-bit word that is all ones when the predicate holds and all zeros otherwise. In the mask mode, each lane yields a single bit of an 8-bit mask, gated by a write mask that always zeroes. The unit also reports an invalid-operation flag and a denormal-operand flag, each ORed over the lanes that take part.

An issuing pipeline presents both source vectors, the previous destination vector, an 8-bit immediate, the mode, the vector length, the write mask and a broadcast flag together with `in_valid`. Exactly one clock later the registered result appears with `out_valid`. In the legacy mode the first operand of each compare is taken from the previous destination rather than from the first source, and destination bits above 128 pass through unchanged. In the mask mode a broadcast flag makes every lane compare against lane 0 of the second source.

Top module: `fcmp_packed_unit`

## Requirements
- R1: `vlen` sets the active lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), 2 or 3 gives 8 lanes (512 bits). Lane i occupies bits [64*i+63:64*i] of every vector port.
- R2: In word-result modes (`mode` 0 legacy, 1 vector), each active lane of `out_vec` is 64'hFFFF_FFFF_FFFF_FFFF when the predicate holds for (A, B) and 64'h0 when it does not. `out_mask` is 0 in these modes.
- R3: Legacy mode (`mode` 0) uses 2 lanes regardless of `vlen`, takes A from `dest_old` (not `src_a`), uses predicate code {00, imm[2:0]}, and copies `dest_old[511:128]` into `out_vec[511:128]`. `wmask` and `bcast` have no effect.
- R4: Vector mode (`mode` 1) takes A from `src_a`, uses predicate code imm[4:0], and drives every `out_vec` bit above the active length to 0. `wmask` and `bcast` have no effect.
- R5: Mask mode (`mode` 2 or 3) sets `out_mask[i]` to the predicate outcome of active lane i, clears mask bits at or above the lane count, and drives `out_vec` to all zeros. The predicate code is imm[4:0].
- R6: In mask mode, a lane whose `wmask` bit is 0 yields 0 in `out_mask`, whatever its compare would give.
- R7: In mask mode with `bcast` set, every lane uses `src_b` lane 0 as its B operand.
- R8: Immediate bits above the predicate field (imm[7:5], and imm[7:3] in legacy mode) do not change any output.
- R9: Predicate code p: relation selected by p[1:0] (0 equal, 1 less, 2 less-or-equal, 3 unordered); when p[3] is 1 the outcome is XORed with "unordered"; when p[2] is 1 it is inverted. Unordered means A or B is a NaN (exponent all ones, nonzero fraction). +0 and -0 compare equal; infinities order normally.
- R10: `flag_invalid` is 1 when some participating lane has a signaling NaN operand (fraction MSB 0) or, with a signaling predicate (p[0]^p[1]^p[4] = 1), a NaN operand of any kind. Participating lanes are active lanes, and in mask mode only those with `wmask` set.
- R11: `flag_denorm` is 1 when some participating lane has an operand with zero exponent and nonzero fraction.
- R12: All outputs are registered: they update one cycle after an `in_valid` cycle with `out_valid` high for that one cycle, and hold otherwise. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 0 legacy, 1 vector, 2 or 3 mask |
| vlen | input | 2 | 0: 128 bits, 1: 256 bits, 2 or 3: 512 bits |
| imm | input | 8 | Immediate carrying the predicate code |
| wmask | input | 8 | Per-lane write mask (mask mode only) |
| bcast | input | 1 | Use second-source lane 0 for all lanes (mask mode only) |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dest_old | input | 512 | Previous destination vector |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_vec | output | 512 | Word-result vector |
| out_mask | output | 8 | Per-lane result mask |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denorm | output | 1 | Denormal-operand flag |

## Verification
Every result, the flags and `out_valid` are due on the first rising edge after the edge that captures `in_valid`, with exactly one register on the way. The bench drives each operation on a falling edge, drops `in_valid` on the next falling edge, and compares all outputs at that moment, half a period after they were loaded. Hold behaviour is checked several cycles later, after the inputs have changed with `in_valid` low, when the outputs must still show the earlier values and `out_valid` must be 0.

// File: rtl/fcmp_pkg.sv
// Package: shared constants and types for the packed binary64 compare unit.
// Assumes lanes are IEEE-754 binary64 words packed with lane 0 in the LSBs.
package fcmp_pkg;
    localparam int LANE_W = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int PRED_W = 5;

    typedef enum logic [1:0] {
        MODE_LEGACY   = 2'd0,
        MODE_VECTOR   = 2'd1,
        MODE_MASK     = 2'd2,
        MODE_MASK_ALT = 2'd3
    } cmp_mode_e;
endpackage

// File: rtl/fcmp_lane.sv
// Module: one lane predicate evaluator.
// Classifies both binary64 operands, derives the less/equal/greater/unordered
// relation, applies the 5-bit predicate code and reports invalid and
// denormal conditions for the lane. Purely combinational.
module fcmp_lane
    import fcmp_pkg::*;
#(
    parameter int W  = LANE_W,
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [PRED_W-1:0] pred,
    output logic              hit,
    output logic              invalid,
    output logic              denorm
);
    localparam int MAG_W = W - 1;

    logic a_nan, b_nan, a_snan, b_snan, a_den, b_den;
    logic unord, both_zero, same_bits, mag_lt, mag_eq, lt_raw;
    logic rel_eq, rel_lt, base, signaling;

    // Classify each operand from its exponent and fraction fields.
    always_comb begin
        a_nan  = (&op_a[W-2 -: EW]) && (|op_a[FW-1:0]);
        b_nan  = (&op_b[W-2 -: EW]) && (|op_b[FW-1:0]);
        a_snan = a_nan && !op_a[FW-1];
        b_snan = b_nan && !op_b[FW-1];
        a_den  = (op_a[W-2 -: EW] == '0) && (|op_a[FW-1:0]);
        b_den  = (op_b[W-2 -: EW] == '0) && (|op_b[FW-1:0]);
    end

    // Derive the ordering relation by sign and magnitude.
    always_comb begin
        unord     = a_nan || b_nan;
        both_zero = (op_a[MAG_W-1:0] == '0) && (op_b[MAG_W-1:0] == '0);
        same_bits = (op_a == op_b);
        mag_lt    = op_a[MAG_W-1:0] < op_b[MAG_W-1:0];
        mag_eq    = op_a[MAG_W-1:0] == op_b[MAG_W-1:0];
        if (op_a[W-1] != op_b[W-1])
            lt_raw = op_a[W-1];
        else if (!op_a[W-1])
            lt_raw = mag_lt;
        else
            lt_raw = !mag_lt && !mag_eq;
        rel_eq = !unord && (both_zero || same_bits);
        rel_lt = !unord && !rel_eq && lt_raw;
    end

    // Apply the predicate code and form the lane flags.
    always_comb begin
        unique case (pred[1:0])
            2'd0:    base = rel_eq;
            2'd1:    base = rel_lt;
            2'd2:    base = rel_lt || rel_eq;
            default: base = unord;
        endcase
        hit       = base ^ (pred[3] & unord) ^ pred[2];
        signaling = pred[0] ^ pred[1] ^ pred[4];
        invalid   = a_snan || b_snan || (signaling && unord);
        denorm    = a_den || b_den;
    end
endmodule

// File: rtl/fcmp_ctrl.sv
// Module: mode and length decode for the packed compare unit.
// Turns mode, vector length, immediate, write mask and broadcast into the
// predicate code, the active-lane vector, the flag-participation vector and
// operand steering controls. Assumes LANES >= 8 is not required; lane counts
// above LANES are clipped.
module fcmp_ctrl
    import fcmp_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int LEG_LANES = 2
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        vlen,
    input  logic [7:0]        imm,
    input  logic [LANES-1:0]  wmask,
    input  logic              bcast,
    output logic [PRED_W-1:0] pred,
    output logic [LANES-1:0]  lane_en,
    output logic [LANES-1:0]  flag_en,
    output logic              is_legacy,
    output logic              is_mask,
    output logic              bcast_eff
);
    localparam int CNT_W = $clog2(LANES + 1);

    cmp_mode_e      mode_e;
    logic [CNT_W-1:0] n_lanes;

    // Decode mode and choose the predicate field width.
    always_comb begin
        mode_e    = cmp_mode_e'(mode);
        is_legacy = (mode_e == MODE_LEGACY);
        is_mask   = (mode_e == MODE_MASK) || (mode_e == MODE_MASK_ALT);
        bcast_eff = is_mask && bcast;
        pred      = is_legacy ? {2'b00, imm[2:0]} : imm[PRED_W-1:0];
    end

    // Pick the active lane count from the mode and vector length.
    always_comb begin
        if (is_legacy)
            n_lanes = CNT_W'(LEG_LANES);
        else begin
            unique case (vlen)
                2'd0:    n_lanes = CNT_W'(2);
                2'd1:    n_lanes = CNT_W'(4);
                default: n_lanes = CNT_W'(8);
            endcase
            if (n_lanes > CNT_W'(LANES))
                n_lanes = CNT_W'(LANES);
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_en
        assign lane_en[i] = (CNT_W'(i) < n_lanes);
        assign flag_en[i] = lane_en[i] && (!is_mask || wmask[i]);
    end
endmodule

// File: rtl/fcmp_packed_unit.sv
// Module: packed binary64 compare unit (top).
// Steers operands to one evaluator per lane, formats word or mask results,
// folds the lane flags and registers everything one cycle after in_valid.
// Assumes the caller holds operands stable only for the in_valid cycle.
module fcmp_packed_unit
    import fcmp_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int LEG_LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              mode,
    input  logic [1:0]              vlen,
    input  logic [7:0]              imm,
    input  logic [LANES-1:0]        wmask,
    input  logic                    bcast,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANES*LANE_W-1:0] dest_old,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_vec,
    output logic [LANES-1:0]        out_mask,
    output logic                    flag_invalid,
    output logic                    flag_denorm
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int LEG_W = LEG_LANES * LANE_W;

    logic [PRED_W-1:0] pred;
    logic [LANES-1:0]  lane_en, flag_en, hit, lane_inv, lane_den;
    logic              is_legacy, is_mask, bcast_eff;
    logic [VEC_W-1:0]  vec_nxt;
    logic [LANES-1:0]  mask_nxt;
    logic              inv_nxt, den_nxt;

    fcmp_ctrl #(.LANES(LANES), .LEG_LANES(LEG_LANES)) u_ctrl (
        .mode      (mode),
        .vlen      (vlen),
        .imm       (imm),
        .wmask     (wmask),
        .bcast     (bcast),
        .pred      (pred),
        .lane_en   (lane_en),
        .flag_en   (flag_en),
        .is_legacy (is_legacy),
        .is_mask   (is_mask),
        .bcast_eff (bcast_eff)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a_sel, b_sel;

        // Select the lane operands: previous destination in legacy mode,
        // second-source lane 0 under broadcast.
        always_comb begin
            a_sel = is_legacy ? dest_old[i*LANE_W +: LANE_W] : src_a[i*LANE_W +: LANE_W];
            b_sel = bcast_eff ? src_b[LANE_W-1:0] : src_b[i*LANE_W +: LANE_W];
        end

        fcmp_lane u_lane (
            .op_a    (a_sel),
            .op_b    (b_sel),
            .pred    (pred),
            .hit     (hit[i]),
            .invalid (lane_inv[i]),
            .denorm  (lane_den[i])
        );

        // Format the lane word: result, pass-through or zero.
        always_comb begin
            if (is_mask)
                vec_nxt[i*LANE_W +: LANE_W] = '0;
            else if (lane_en[i])
                vec_nxt[i*LANE_W +: LANE_W] = {LANE_W{hit[i]}};
            else if (is_legacy)
                vec_nxt[i*LANE_W +: LANE_W] = dest_old[i*LANE_W +: LANE_W];
            else
                vec_nxt[i*LANE_W +: LANE_W] = '0;
        end
    end

    // Build the mask result and fold flags over participating lanes.
    always_comb begin
        mask_nxt = is_mask ? (hit & flag_en) : '0;
        inv_nxt  = |(lane_inv & flag_en);
        den_nxt  = |(lane_den & flag_en);
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_vec      <= '0;
            out_mask     <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec      <= vec_nxt;
                out_mask     <= mask_nxt;
                flag_invalid <= inv_nxt;
                flag_denorm  <= den_nxt;
            end
        end
    end

    // R12: out_valid appears exactly one cycle after in_valid.
    a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12: with no input strobe the result holds.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec) && $stable(out_mask) && !out_valid);

    // R3: legacy mode passes the upper destination bits through.
    a_r3_upper_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=> out_vec[VEC_W-1:LEG_W] == $past(dest_old[VEC_W-1:LEG_W]));

    // R4: vector mode at 128 bits clears all upper bits.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1 && vlen == 2'd0) |=> out_vec[VEC_W-1:LEG_W] == '0);

    // R5: mask mode at 128 bits leaves mask bits 2 and up clear and the vector zero.
    a_r5_mask_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && vlen == 2'd0) |=> (out_mask[LANES-1:LEG_LANES] == '0) && (out_vec == '0));

    // R6: a write-masked lane never sets its mask bit.
    a_r6_zero_masking: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && !wmask[0]) |=> !out_mask[0]);

    // R10 / R11: an all-zero write mask in mask mode raises no flag.
    a_r10_masked_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && wmask == '0) |=> !flag_invalid && !flag_denorm);

    // R2: the low lane words are always all ones or all zeros.
    for (genvar k = 0; k < LEG_LANES; k++) begin : g_chk
        a_r2_word_form: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_vec[k*LANE_W +: LANE_W] == '0) || (&out_vec[k*LANE_W +: LANE_W]));
    end
endmodule

// File: tb/fcmp_packed_unit_test.sv
module fcmp_packed_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = '0;
    logic [1:0]   vlen = '0;
    logic [7:0]   imm = '0;
    logic [7:0]   wmask = '0;
    logic         bcast = 1'b0;
    logic [511:0] src_a = '0, src_b = '0, dest_old = '0;
    logic         out_valid;
    logic [511:0] out_vec;
    logic [7:0]   out_mask;
    logic         flag_invalid, flag_denorm;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] TWO  = 64'h4000000000000000;
    localparam logic [63:0] NEG1 = 64'hBFF0000000000000;
    localparam logic [63:0] NEG2 = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] SNAN = 64'h7FF0000000000001;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] DEN1 = 64'h0000000000000001;
    localparam logic [63:0] DEN2 = 64'h0000000000000003;

    always #2.5 clk = ~clk;

    fcmp_packed_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .vlen(vlen),
        .imm(imm), .wmask(wmask), .bcast(bcast), .src_a(src_a), .src_b(src_b),
        .dest_old(dest_old), .out_valid(out_valid), .out_vec(out_vec),
        .out_mask(out_mask), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
    );

    function automatic logic is_nan(logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction
    function automatic logic is_snan(logic [63:0] x);
        return is_nan(x) && !x[51];
    endfunction
    function automatic logic is_den(logic [63:0] x);
        return (x[62:52] == 0) && (x[51:0] != 0);
    endfunction

    // Predicate outcome from the relation sets listed per code (R9).
    function automatic logic pred_true(logic [4:0] p, logic [63:0] a, logic [63:0] b);
        logic un, lt, eq, gt;
        real ra, rb;
        un = is_nan(a) || is_nan(b);
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        lt = !un && (ra < rb);
        eq = !un && (ra == rb);
        gt = !un && (ra > rb);
        case (p[3:0])
            4'h0: return eq;
            4'h1: return lt;
            4'h2: return lt || eq;
            4'h3: return un;
            4'h4: return lt || gt || un;
            4'h5: return eq || gt || un;
            4'h6: return gt || un;
            4'h7: return lt || eq || gt;
            4'h8: return eq || un;
            4'h9: return lt || un;
            4'hA: return lt || eq || un;
            4'hB: return 1'b0;
            4'hC: return lt || gt;
            4'hD: return eq || gt;
            4'hE: return gt;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic pred_sig(logic [4:0] p);
        logic s;
        case (p[3:0])
            4'h1, 4'h2, 4'h5, 4'h6, 4'h9, 4'hA, 4'hD, 4'hE: s = 1'b1;
            default: s = 1'b0;
        endcase
        return s ^ p[4];
    endfunction

    task automatic check(string req, string what, logic [511:0] got, logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one operation and compare every output one cycle later.
    task automatic run(string req, logic [1:0] md, logic [1:0] vl, logic [7:0] im,
                       logic [7:0] wm, logic bc, logic [511:0] a, logic [511:0] b,
                       logic [511:0] d);
        logic [511:0] ev;
        logic [7:0]   em;
        logic         ei, ed;
        int           n;
        logic [4:0]   p;
        @(negedge clk);
        mode = md; vlen = vl; imm = im; wmask = wm; bcast = bc;
        src_a = a; src_b = b; dest_old = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n = (md == 0 || vl == 0) ? 2 : (vl == 1) ? 4 : 8;
        p = (md == 0) ? {2'b00, im[2:0]} : im[4:0];
        ev = '0; em = '0; ei = 0; ed = 0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                logic [63:0] la, lb;
                logic act, h;
                la  = (md == 0) ? d[64*i +: 64] : a[64*i +: 64];
                lb  = (md[1] && bc) ? b[63:0] : b[64*i +: 64];
                act = md[1] ? wm[i] : 1'b1;
                h   = pred_true(p, la, lb);
                if (act) begin
                    ei |= is_snan(la) || is_snan(lb) || (pred_sig(p) && (is_nan(la) || is_nan(lb)));
                    ed |= is_den(la) || is_den(lb);
                end
                if (!md[1]) ev[64*i +: 64] = {64{h}};
                else em[i] = act && h;
            end else if (md == 0) begin
                ev[64*i +: 64] = d[64*i +: 64];
            end
        end
        check(req, "out_valid", 512'(out_valid), 512'(1'b1));
        check(req, "out_vec", out_vec, ev);
        check(req, "out_mask", 512'(out_mask), 512'(em));
        check(req, "flag_invalid", 512'(flag_invalid), 512'(ei));
        check(req, "flag_denorm", 512'(flag_denorm), 512'(ed));
    endtask

    function automatic logic [63:0] xs(logic [63:0] s);
        s ^= s << 13; s ^= s >> 7; s ^= s << 17;
        return s;
    endfunction

    logic [511:0] va, vb, vd;

    initial begin
        va = {DEN2, PINF, NEG1, QNAN, PZ, ONE, TWO, ONE};
        vb = {DEN1, NINF, NEG2, ONE,  NZ, ONE, ONE, TWO};
        vd = {64'h1111111111111111, 64'h2222222222222222, 64'h3333333333333333,
              64'h4444444444444444, 64'h5555555555555555, 64'h6666666666666666,
              TWO, ONE};

        repeat (3) @(negedge clk);
        // R12: reset state.
        check("R12", "reset out_valid", 512'(out_valid), '0);
        check("R12", "reset out_vec", out_vec, '0);
        check("R12", "reset mask/flags", 512'({out_mask, flag_invalid, flag_denorm}), '0);
        rst_n = 1'b1;

        // R2 R9 R10 R11: every predicate in vector mode over 8 relation cases.
        for (int p = 0; p < 32; p++)
            run("R2_R9", 2'd1, 2'd2, 8'(p), 8'h00, 1'b0, va, vb, vd);

        // R1 R4: each length with the always-true predicate.
        for (int v = 0; v < 4; v++)
            run("R1_R4", 2'd1, 2'(v), 8'h0F, 8'hFF, 1'b1, va, vb, vd);

        // R3: legacy mode uses dest_old as A, imm[2:0], passes upper bits.
        for (int p = 0; p < 8; p++) begin
            run("R3", 2'd0, 2'd2, 8'(p), 8'h00, 1'b0, vb, vb, vd);
            run("R3_R8", 2'd0, 2'd1, 8'(p) | 8'hF8, 8'h3C, 1'b1, va, vb, {va[511:128], vd[127:0]});
        end

        // R5 R6: mask mode over predicates, write masks and lengths.
        for (int p = 0; p < 32; p++) begin
            run("R5_R6", 2'd2, 2'd2, 8'(p), 8'hFF, 1'b0, va, vb, vd);
            run("R5_R6", 2'd3, 2'd2, 8'(p), 8'h55, 1'b0, va, vb, vd);
            run("R5_R6", 2'd2, 2'd0, 8'(p), 8'hFE, 1'b0, va, vb, vd);
        end
        run("R6", 2'd2, 2'd2, 8'h0F, 8'h00, 1'b0, va, vb, vd);

        // R7: broadcast of second-source lane 0.
        for (int p = 0; p < 8; p++)
            run("R7", 2'd2, 2'd2, 8'(p), 8'hFF, 1'b1, va, vb, vd);
        run("R7", 2'd2, 2'd1, 8'h0E, 8'hFF, 1'b1, va, {vb[511:64], NEG2}, vd);

        // R10: signaling NaN with a quiet predicate, unmasked then masked.
        run("R10", 2'd2, 2'd2, 8'h00, 8'hFF, 1'b0, {va[511:192], SNAN, va[127:0]}, vb, vd);
        run("R10", 2'd2, 2'd2, 8'h00, 8'hF7, 1'b0, {va[511:256], SNAN, va[191:0]}, vb, vd);
        run("R10", 2'd1, 2'd0, 8'h00, 8'h00, 1'b0, {va[511:256], SNAN, va[191:0]}, vb, vd);

        // R8: reserved bits in vector and mask modes.
        run("R8", 2'd1, 2'd2, 8'hE1, 8'h00, 1'b0, va, vb, vd);
        run("R8", 2'd2, 2'd2, 8'hA9, 8'hFF, 1'b0, va, vb, vd);

        // R9: pseudo-random operands and predicates.
        begin
            logic [63:0] s;
            s = 64'h9E3779B97F4A7C15;
            for (int it = 0; it < 150; it++) begin
                logic [511:0] ra, rb;
                for (int l = 0; l < 8; l++) begin
                    s = xs(s); ra[64*l +: 64] = s;
                    s = xs(s); rb[64*l +: 64] = (s[3:0] == 0) ? ra[64*l +: 64] : s;
                end
                s = xs(s);
                run("R9", s[9:8], s[11:10], s[7:0], s[19:12], s[20], ra, rb, vd);
            end
        end

        // R12: outputs hold while in_valid stays low.
        run("R12", 2'd1, 2'd1, 8'h02, 8'h00, 1'b0, va, vb, vd);
        begin
            logic [511:0] keep_v;
            logic [7:0]   keep_m;
            keep_v = out_vec; keep_m = out_mask;
            mode = 2'd2; imm = 8'h0F; wmask = 8'hFF; src_a = vb; src_b = va;
            repeat (4) @(negedge clk);
            check("R12", "hold out_vec", out_vec, keep_v);
            check("R12", "hold out_mask", 512'(out_mask), 512'(keep_m));
            check("R12", "hold out_valid low", 512'(out_valid), '0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule